// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register File

This block keeps the inter-processor interrupt state of a single core. It holds a 32-bit pending vector, a 32-bit enable register and a 32-byte mailbox area made of four 64-bit words. The core owns the interrupt line. The line is high whenever any pending bit is set. Remote senders raise pending bits one at a time, and the owning core retires them by writing ones to a clear register.

Software on the core uses a request/response register port. Each request carries an address, a size code and a 64-bit write value. The response comes back one cycle later with read data, an error flag and a misalignment flag. Only address bits [8:0] take part in decode. A second port is driven by the cross-core send router. It can set one pending bit by index. It can also write one 32-bit mailbox word under a per-byte keep mask, which leaves the kept bytes unchanged.

Top module: `ipi_regfile`

## Requirements
- R1: After reset the pending vector, the enable register and all 32 mailbox bytes read as zero, and `irq_o` is low.
- R2: Decode uses `sw_addr[8:0]` only. Accesses that differ only in higher address bits behave the same.
- R3: A router set with index k ORs bit k into the pending vector at the next clock edge. `irq_o` is high after that same edge.
- R4: Setting a bit while the pending vector is already nonzero keeps `irq_o` high with no low cycle.
- R5: A write to offset 0x0C clears every pending bit that is 1 in `sw_wdata[31:0]`. `irq_o` is low after the edge on which the vector becomes zero. If a router set arrives in the same cycle, the set wins for its bit.
- R6: Reads of offsets 0x08 (set) and 0x0C (clear) return zero without error, even while bits are pending.
- R7: Writes to offsets 0x00 (pending) and 0x08 (set) return `sw_err`=1 and change no state.
- R8: Offset 0x04 is a plain 32-bit enable register. A write stores `sw_wdata[31:0]` and a read returns it zero-extended.
- R9: The mailbox spans offsets 0x20..0x3F, byte-addressed and little-endian. `sw_size` 0, 1, 2, 3 selects 1, 2, 4 or 8 bytes. A write changes only bytes offset..offset+n-1, taken from the low bytes of `sw_wdata`. A read returns those bytes in the low lanes, with the upper lanes zero.
- R10: A mailbox access with offset+n > 0x40 returns `sw_err`=1 with zero read data and changes nothing. So does any offset other than 0x00, 0x04, 0x08, 0x0C or 0x20..0x3F.
- R11: `sw_misalign` is 1 when the offset is not a multiple of the access size n. An in-range access still completes.
- R12: A router mailbox write with word index w covers bytes 0x20+4w..0x20+4w+3. Byte b of that word takes `rt_mb_data[8b+7:8b]` when `rt_mb_keep[b]`=0 and keeps its old value when `rt_mb_keep[b]`=1. On a byte collision with a software write in the same cycle, the router wins.
- R13: Each cycle with `sw_req`=1 produces exactly one `sw_ack` pulse in the next cycle, with data sampled from state before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software access valid for this cycle |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_addr | input | ADDR_W (16) | Byte address; bits [8:0] decoded |
| sw_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| sw_wdata | input | 64 | Write value, little-endian lanes |
| sw_ack | output | 1 | Response valid, one cycle after request |
| sw_rdata | output | 64 | Read data, zero-extended |
| sw_err | output | 1 | Access rejected |
| sw_misalign | output | 1 | Offset not a multiple of size |
| rt_set_valid | input | 1 | Router sets one pending bit |
| rt_set_vec | input | 5 | Index of the bit to set |
| rt_mb_valid | input | 1 | Router masked mailbox word write |
| rt_mb_word | input | 3 | 32-bit mailbox word index 0..7 |
| rt_mb_keep | input | 4 | Per-byte keep mask, 1 = keep old byte |
| rt_mb_data | input | 32 | Router mailbox word value |
| irq_o | output | 1 | Interrupt to the core, high while any bit is pending |

## Verification
The properties assume that the two ports never collide on the pending vector in a way the checks do not expect. The clear-effect property is only armed when no router set lands in the same cycle. They also assume that software issues at most one request per cycle and holds its fields stable for that cycle. The stimulus meets these assumptions in two ways. It serializes all traffic, so router sets and software clears never share a cycle. It drives each request for exactly one cycle, shortly after a rising edge, and samples results on falling edges.

// File: rtl/ipi_regfile.sv
module ipi_regfile #(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 32,
  parameter int MBOX_WORDS = 4,
  parameter int MB_BASE    = 32,
  localparam int VEC_W     = $clog2(REG_W),
  localparam int MB_BYTES  = MBOX_WORDS * 8,
  localparam int MBW_W     = $clog2(MB_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [1:0]        sw_size,
  input  logic [63:0]       sw_wdata,
  output logic              sw_ack,
  output logic [63:0]       sw_rdata,
  output logic              sw_err,
  output logic              sw_misalign,
  input  logic              rt_set_valid,
  input  logic [VEC_W-1:0]  rt_set_vec,
  input  logic              rt_mb_valid,
  input  logic [MBW_W-1:0]  rt_mb_word,
  input  logic [3:0]        rt_mb_keep,
  input  logic [31:0]       rt_mb_data,
  output logic              irq_o
);
  localparam int MB_END   = MB_BASE + MB_BYTES;
  localparam int MB_IDX_W = $clog2(MB_BYTES);
  localparam logic [8:0] OFF_STAT = 9'h000;
  localparam logic [8:0] OFF_EN   = 9'h004;
  localparam logic [8:0] OFF_SET  = 9'h008;
  localparam logic [8:0] OFF_CLR  = 9'h00C;

  logic [REG_W-1:0]    status_q, status_d, en_q, clr_mask, set_mask;
  logic [7:0]          mb_q [MB_BYTES];
  logic [7:0]          mb_d [MB_BYTES];
  logic                irq_q;
  logic [8:0]          off;
  logic [3:0]          nbytes;
  logic [9:0]          off_end;
  logic                is_stat, is_en, is_set, is_clr, in_mb, mb_over, unknown;
  logic                acc_err, acc_mis, sw_wr;
  logic [MB_IDX_W-1:0] boff;
  logic [63:0]         rd;

  wire unused_hi = ^sw_addr[ADDR_W-1:9];

  assign off     = sw_addr[8:0];
  assign nbytes  = 4'd1 << sw_size;
  assign off_end = {1'b0, off} + {6'd0, nbytes};
  assign is_stat = off == OFF_STAT;
  assign is_en   = off == OFF_EN;
  assign is_set  = off == OFF_SET;
  assign is_clr  = off == OFF_CLR;
  assign in_mb   = ({1'b0, off} >= 10'(MB_BASE)) && ({1'b0, off} < 10'(MB_END));
  assign mb_over = in_mb && (off_end > 10'(MB_END));
  assign unknown = !(is_stat || is_en || is_set || is_clr || in_mb);
  assign acc_err = unknown || mb_over || (sw_we && (is_stat || is_set));
  assign acc_mis = |(off[3:0] & (nbytes - 4'd1));
  assign boff    = MB_IDX_W'(off - 9'(MB_BASE));
  assign sw_wr   = sw_req && sw_we && !acc_err;

  assign clr_mask = (sw_wr && is_clr) ? sw_wdata[REG_W-1:0] : '0;
  assign set_mask = rt_set_valid ? (REG_W'(1) << rt_set_vec) : '0;
  assign status_d = (status_q & ~clr_mask) | set_mask;
  assign irq_o    = irq_q;

  always_comb begin
    for (int j = 0; j < MB_BYTES; j++) begin
      mb_d[j] = mb_q[j];
      if (sw_wr && in_mb && j >= int'(boff) && j < int'(boff) + int'(nbytes))
        mb_d[j] = sw_wdata[8*(j-int'(boff)) +: 8];
      if (rt_mb_valid && (j / 4) == int'(rt_mb_word) && !rt_mb_keep[j%4])
        mb_d[j] = rt_mb_data[8*(j%4) +: 8];
    end
  end

  always_comb begin
    rd = '0;
    if (!acc_err && !sw_we) begin
      if (is_stat)
        rd = 64'(status_q);
      else if (is_en)
        rd = 64'(en_q);
      else if (in_mb)
        for (int i = 0; i < 8; i++)
          if (i < int'(nbytes))
            rd[8*i +: 8] = mb_q[MB_IDX_W'(int'(boff) + i)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= '0;
      en_q        <= '0;
      irq_q       <= 1'b0;
      sw_ack      <= 1'b0;
      sw_rdata    <= '0;
      sw_err      <= 1'b0;
      sw_misalign <= 1'b0;
      for (int j = 0; j < MB_BYTES; j++) mb_q[j] <= '0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
      if (sw_wr && is_en) en_q <= sw_wdata[REG_W-1:0];
      for (int j = 0; j < MB_BYTES; j++) mb_q[j] <= mb_d[j];
      sw_ack <= sw_req;
      if (sw_req) begin
        sw_rdata    <= rd;
        sw_err      <= acc_err;
        sw_misalign <= acc_mis;
      end
    end
  end
endmodule

// File: rtl/ipi_regfile_chk.sv
module ipi_regfile_chk #(
  parameter int REG_W = 32,
  localparam int VEC_W = $clog2(REG_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_req,
  input logic             sw_we,
  input logic [8:0]       off,
  input logic [REG_W-1:0] wlo,
  input logic             sw_ack,
  input logic             sw_err,
  input logic [63:0]      sw_rdata,
  input logic             rt_set_valid,
  input logic [VEC_W-1:0] rt_set_vec,
  input logic             irq_o,
  input logic [REG_W-1:0] status
);
  // R13
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> sw_ack);
  // R13
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_req |=> !sw_ack);
  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_set_valid |=> status[$past(rt_set_vec)]);
  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && rt_set_valid) |=> irq_o);
  // R5
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_we && off == 9'h00C && !rt_set_valid) |=> ((status & $past(wlo)) == '0));
  // R5
  irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (status != '0));
  // R7
  reject_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_we && (off == 9'h000 || off == 9'h008)) |=> sw_err);
  // R7
  status_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_we && off == 9'h000 && !rt_set_valid) |=> $stable(status));
  // R6
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !sw_we && (off == 9'h008 || off == 9'h00C)) |=> (sw_rdata == '0 && !sw_err));
endmodule

bind ipi_regfile ipi_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_we(sw_we),
  .off(sw_addr[8:0]), .wlo(sw_wdata[31:0]), .sw_ack(sw_ack),
  .sw_err(sw_err), .sw_rdata(sw_rdata), .rt_set_valid(rt_set_valid),
  .rt_set_vec(rt_set_vec), .irq_o(irq_o), .status(status_q)
);

// File: tb/tb_ipi_regfile.sv
module tb_ipi_regfile;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sw_req, sw_we, sw_ack, sw_err, sw_misalign;
  logic [15:0] sw_addr;
  logic [1:0]  sw_size;
  logic [63:0] sw_wdata, sw_rdata;
  logic        rt_set_valid, rt_mb_valid, irq_o;
  logic [4:0]  rt_set_vec;
  logic [2:0]  rt_mb_word;
  logic [3:0]  rt_mb_keep;
  logic [31:0] rt_mb_data;

  ipi_regfile dut (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_size(sw_size), .sw_wdata(sw_wdata), .sw_ack(sw_ack), .sw_rdata(sw_rdata),
    .sw_err(sw_err), .sw_misalign(sw_misalign), .rt_set_valid(rt_set_valid),
    .rt_set_vec(rt_set_vec), .rt_mb_valid(rt_mb_valid), .rt_mb_word(rt_mb_word),
    .rt_mb_keep(rt_mb_keep), .rt_mb_data(rt_mb_data), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [65:0] exp_q [$];
  string       tag_q [$];
  bit [31:0]   m_status, m_en;
  logic [7:0]  m_mb [32];

  task automatic sw_op(input bit we, input logic [15:0] addr, input logic [1:0] sz,
                       input logic [63:0] wd, input string tag);
    logic [63:0] r;
    bit e, m;
    int off, n;
    off = int'(addr[8:0]);
    n = 1 << sz;
    m = (off % n) != 0;
    r = '0;
    e = 0;
    if (off >= 32 && off < 64) begin
      if (off + n > 64) e = 1;
      else
        for (int i = 0; i < n; i++)
          if (we) m_mb[off-32+i] = wd[8*i +: 8];
          else    r[8*i +: 8] = m_mb[off-32+i];
    end else begin
      case (off)
        0:  if (we) e = 1; else r = 64'(m_status);
        4:  if (we) m_en = wd[31:0]; else r = 64'(m_en);
        8:  if (we) e = 1;
        12: if (we) m_status = m_status & ~wd[31:0];
        default: e = 1;
      endcase
    end
    exp_q.push_back({m, e, r});
    tag_q.push_back(tag);
    sw_req = 1; sw_we = we; sw_addr = addr; sw_size = sz; sw_wdata = wd;
    @(posedge clk); #1;
    sw_req = 0;
  endtask

  task automatic rt_set(input logic [4:0] v);
    m_status = m_status | (32'd1 << v);
    rt_set_valid = 1; rt_set_vec = v;
    @(posedge clk); #1;
    rt_set_valid = 0;
  endtask

  task automatic rt_mb(input logic [2:0] w, input logic [3:0] keep, input logic [31:0] d);
    for (int b = 0; b < 4; b++)
      if (!keep[b]) m_mb[int'(w)*4+b] = d[8*b +: 8];
    rt_mb_valid = 1; rt_mb_word = w; rt_mb_keep = keep; rt_mb_data = d;
    @(posedge clk); #1;
    rt_mb_valid = 0;
  endtask

  task automatic check_irq(input string tag);
    @(negedge clk);
    checks++;
    if (irq_o !== (m_status != 0)) begin
      errors++;
      $display("FAIL %s: irq_o=%0b expected %0b", tag, irq_o, (m_status != 0));
    end
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && sw_ack) begin
      logic [65:0] ex;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13: unexpected ack, got rdata=%h expected no response", sw_rdata);
      end else begin
        ex = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({sw_misalign, sw_err, sw_rdata} !== ex) begin
          errors++;
          $display("FAIL %s: got mis=%0b err=%0b rdata=%h, expected mis=%0b err=%0b rdata=%h",
                   t, sw_misalign, sw_err, sw_rdata, ex[65], ex[64], ex[63:0]);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R13: watchdog expired, got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sw_req = 0; sw_we = 0; sw_addr = '0; sw_size = '0; sw_wdata = '0;
    rt_set_valid = 0; rt_set_vec = '0; rt_mb_valid = 0; rt_mb_word = '0;
    rt_mb_keep = '0; rt_mb_data = '0;
    m_status = '0; m_en = '0;
    for (int i = 0; i < 32; i++) m_mb[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    check_irq("R1");
    sw_op(0, 16'h0000, 2, 0, "R1");
    sw_op(0, 16'h0004, 2, 0, "R1");
    for (int w = 0; w < 4; w++) sw_op(0, 16'(32 + 8*w), 3, 0, "R1");

    // R8 enable register
    sw_op(1, 16'h0004, 2, 64'hFFFF_0000_DEAD_BEEF, "R8");
    sw_op(0, 16'h0004, 2, 0, "R8");

    // R2 upper address bits ignored
    sw_op(1, 16'hFE04, 2, 64'h1234_5678, "R2");
    sw_op(0, 16'h0004, 2, 0, "R2");
    sw_op(0, 16'hA004, 2, 0, "R2");

    // R3 router set
    rt_set(5);
    check_irq("R3");
    sw_op(0, 16'h0000, 2, 0, "R3");

    // R4 set while pending
    rt_set(9);
    check_irq("R4");
    rt_set(9);
    check_irq("R4");
    sw_op(0, 16'h0000, 2, 0, "R4");

    // R5 clear
    sw_op(1, 16'h000C, 2, 64'h20, "R5");
    check_irq("R5");
    sw_op(1, 16'h000C, 2, 64'hFFFF_FFFF, "R5");
    check_irq("R5");
    sw_op(0, 16'h0000, 2, 0, "R5");

    // R6 set/clear read as zero while pending
    rt_set(3);
    sw_op(0, 16'h0008, 2, 0, "R6");
    sw_op(0, 16'h000C, 2, 0, "R6");

    // R7 rejected writes
    sw_op(1, 16'h0000, 2, 64'hFFFF_FFFF, "R7");
    sw_op(1, 16'h0008, 2, 64'h1, "R7");
    sw_op(0, 16'h0000, 2, 0, "R7");
    check_irq("R7");

    // R9 mailbox sizes
    sw_op(1, 16'h0020, 3, 64'h0123_4567_89AB_CDEF, "R9");
    sw_op(1, 16'h0023, 0, 64'h55AA, "R9");
    sw_op(0, 16'h0020, 3, 0, "R9");
    sw_op(0, 16'h0022, 1, 0, "R9");
    sw_op(1, 16'h003C, 2, 64'h1111_2222_CAFE_F00D, "R9");
    sw_op(0, 16'h0038, 3, 0, "R9");
    sw_op(0, 16'h003C, 2, 0, "R9");
    sw_op(1, 16'h002A, 1, 64'h7777_BEEF, "R9");
    sw_op(0, 16'h0028, 3, 0, "R9");
    sw_op(0, 16'h002B, 0, 0, "R9");

    // R10 overrun and unknown offsets
    sw_op(1, 16'h003C, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
    sw_op(1, 16'h003E, 2, 64'hFFFF_FFFF, "R10");
    sw_op(0, 16'h003F, 1, 0, "R10");
    sw_op(0, 16'h0010, 2, 0, "R10");
    sw_op(1, 16'h0040, 0, 64'hFF, "R10");
    sw_op(0, 16'h01FF, 0, 0, "R10");
    sw_op(0, 16'h0038, 3, 0, "R10");

    // R11 misalignment
    sw_op(0, 16'h0022, 2, 0, "R11");
    sw_op(0, 16'h0021, 1, 0, "R11");
    sw_op(0, 16'h0024, 2, 0, "R11");
    sw_op(1, 16'h0031, 1, 64'h9876, "R11");
    sw_op(0, 16'h0030, 3, 0, "R11");

    // R12 router masked mailbox writes
    rt_mb(3'd2, 4'b0101, 32'hA1B2_C3D4);
    sw_op(0, 16'h0028, 3, 0, "R12");
    rt_mb(3'd7, 4'b1111, 32'h0BAD_0BAD);
    sw_op(0, 16'h003C, 2, 0, "R12");
    rt_mb(3'd0, 4'b0000, 32'h0F0E_0D0C);
    sw_op(0, 16'h0020, 3, 0, "R12");

    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule